// File: doc/BRIEF.md
# Unaligned Byte Stream to Word Write Packer

This block accepts a write request made of a byte start address and a byte length, followed by a stream of bytes. It turns that stream into aligned 32-bit word writes for a memory that only takes whole words. Lanes of a word that the request does not cover, whether below the start offset in the first word or above the last byte in the final word, are loaded with 0xFF. Programming 0xFF leaves erased flash cells as they are, so no byte enables and no read-modify-write are needed.

A request is accepted only while the block is idle. Each word is offered on a valid/ready port along with its word address. The writer answers a failed write by raising a fail flag in the same cycle as ready. At the end of a request the block pulses a done flag with a result code and the number of bytes held in words that were written successfully. An empty request, or one that runs past the end of the configured memory, finishes without issuing any word.

Top module: `bytepack_wr`

## Requirements
- R1: When the start address is not a multiple of 4, the first word goes to word address `cmd_addr >> 2`. Its lanes below `cmd_addr[1:0]` are 0xFF. Lane k is `wr_data[8k+7:8k]`, and lane 0 holds the lowest byte address.
- R2: The first word takes stream bytes into successive lanes until lane 3 is filled or the length is used up. Any lanes above that are 0xFF.
- R3: Complete 4-byte groups between the two partial ends are written unchanged, with the lowest address in lane 0, at consecutive word addresses.
- R4: A final group of 1 to 3 bytes is written as one word whose unused upper lanes are 0xFF.
- R5: A request with length 0 raises `done` on the clock edge after it is accepted, with code 0 (ok) and a byte count of 0. No word is issued.
- R6: A request with nonzero length and `cmd_addr + cmd_len > MEM_BYTES` completes with code 1 (range) and a byte count of 0. No word is issued. An end exactly at `MEM_BYTES` is accepted.
- R7: When a word handshake carries `wr_fail = 1`, the block returns to idle and raises `done` with code 2 (write fail). The count covers only the bytes of words that were accepted earlier without failure. A later request runs normally.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_word_addr` and `wr_data` hold their values, so a stall of any length loses and reorders nothing.
- R9: A request that completes without failure raises `done` with code 0 and a count equal to `cmd_len`.
- R10: `cmd_ready` is high only while the block is idle. `in_ready` is never high while a word is pending, and never high while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Request offered |
| cmd_ready | output | 1 | Block idle, request taken |
| cmd_addr | input | ADDR_W | Byte start address |
| cmd_len | input | LEN_W | Byte length |
| in_valid | input | 1 | Stream byte offered |
| in_ready | output | 1 | Stream byte taken |
| in_byte | input | 8 | Stream byte |
| wr_valid | output | 1 | Word write offered |
| wr_ready | input | 1 | Word write taken |
| wr_fail | input | 1 | Taken word failed (valid with ready) |
| wr_word_addr | output | ADDR_W-2 | Word address |
| wr_data | output | 32 | Word data, lane 0 in bits 7:0 |
| done | output | 1 | One-cycle completion pulse |
| done_code | output | 2 | 0 ok, 1 range, 2 write fail |
| done_bytes | output | LEN_W | Bytes committed |

## Verification
If a lane pointer or remaining-byte counter holds a wrong value, the word handshake that follows shows it right away. The word is either issued too early with 0xFF in a lane meant for data, or a stream byte lands in the wrong lane. A scoreboard comparing address and data on every accepted word flags either case on that same handshake. If the committed count is off, or the FSM leaves a pending word at the wrong time, `done_bytes` or `done_code` is wrong on the single done pulse, or an extra or missing word shows up against the scoreboard queue. Stalls and byte gaps are mixed in so that a state change taken without a handshake shows up as a changed or repeated word.

// File: rtl/bytepack_pkg.sv
package bytepack_pkg;
  localparam int LANES = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam logic [7:0] ERASED = 8'hFF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2
  } st_e;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_RANGE = 2'd1,
    RES_WFAIL = 2'd2
  } res_e;
endpackage

// File: rtl/bytepack_range.sv
module bytepack_range #(
  parameter int ADDR_W = 20,
  parameter int LEN_W = 12,
  parameter int unsigned MEM_BYTES = 32'h0010_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              len_zero,
  output logic              past_end
);
  localparam int SUM_W = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(MEM_BYTES);

  logic [SUM_W-1:0] end_addr;

  always_comb begin
    end_addr = SUM_W'(addr) + SUM_W'(len);
    len_zero = (len == '0);
    past_end = (end_addr > LIMIT);
  end
endmodule

// File: rtl/bytepack_lanes.sv
module bytepack_lanes
  import bytepack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [7:0]        wr_byte,
  output logic [8*LANES-1:0] word
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic       lane_en;
    logic [7:0] lane_d;
    logic [7:0] lane_q;

    always_comb begin
      lane_en = clr | (wr_en && (wr_lane == LANE_W'(g)));
      lane_d  = clr ? ERASED : wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q <= ERASED;
      end else if (lane_en) begin
        lane_q <= lane_d;
      end
    end

    assign word[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/bytepack_ctrl.sv
module bytepack_ctrl
  import bytepack_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              len_zero,
  input  logic              past_end,
  input  logic              in_valid,
  input  logic              wr_ready,
  input  logic              wr_fail,
  output logic              cmd_ready,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [ADDR_W-3:0] word_addr,
  output logic              buf_clr,
  output logic              buf_wr,
  output logic [LANE_W-1:0] lane,
  output logic              done,
  output logic [1:0]        done_code,
  output logic [LEN_W-1:0]  done_bytes
);
  localparam int WA_W = ADDR_W - 2;
  localparam int PEND_W = LANE_W + 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  st_e               st_q, st_d;
  logic [WA_W-1:0]   waddr_q, waddr_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [LEN_W-1:0]  commit_q, commit_d;
  logic              done_q, done_d;
  res_e              code_q, code_d;
  logic              cmd_fire, in_fire, wr_fire, ctx_en;

  always_comb begin
    cmd_fire = cmd_valid && (st_q == ST_IDLE);
    in_fire  = in_valid && (st_q == ST_FILL);
    wr_fire  = wr_ready && (st_q == ST_SEND);
    ctx_en   = cmd_fire | in_fire | wr_fire;
  end

  always_comb begin
    st_d     = st_q;
    waddr_d  = waddr_q;
    lane_d   = lane_q;
    left_d   = left_q;
    pend_d   = pend_q;
    commit_d = commit_q;
    code_d   = code_q;
    done_d   = 1'b0;
    buf_clr  = 1'b0;
    buf_wr   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          commit_d = '0;
          if (len_zero) begin
            done_d = 1'b1;
            code_d = RES_OK;
          end else if (past_end) begin
            done_d = 1'b1;
            code_d = RES_RANGE;
          end else begin
            st_d    = ST_FILL;
            waddr_d = cmd_addr[ADDR_W-1:2];
            lane_d  = cmd_addr[LANE_W-1:0];
            left_d  = cmd_len;
            pend_d  = '0;
            buf_clr = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (in_valid) begin
          buf_wr = 1'b1;
          lane_d = lane_q + 1'b1;
          left_d = left_q - 1'b1;
          pend_d = pend_q + 1'b1;
          if ((lane_q == LAST_LANE) || (left_q == LEN_W'(1))) begin
            st_d = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        if (wr_ready) begin
          if (wr_fail) begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            code_d = RES_WFAIL;
          end else begin
            commit_d = commit_q + LEN_W'(pend_q);
            if (left_q == '0) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
              code_d = RES_OK;
            end else begin
              st_d    = ST_FILL;
              waddr_d = waddr_q + 1'b1;
              lane_d  = '0;
              pend_d  = '0;
              buf_clr = 1'b1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q  <= '0;
      lane_q   <= '0;
      left_q   <= '0;
      pend_q   <= '0;
      commit_q <= '0;
      code_q   <= RES_OK;
    end else if (ctx_en) begin
      waddr_q  <= waddr_d;
      lane_q   <= lane_d;
      left_q   <= left_d;
      pend_q   <= pend_d;
      commit_q <= commit_d;
      code_q   <= code_d;
    end
  end

  always_comb begin
    cmd_ready  = (st_q == ST_IDLE);
    in_ready   = (st_q == ST_FILL);
    wr_valid   = (st_q == ST_SEND);
    word_addr  = waddr_q;
    lane       = lane_q;
    done       = done_q;
    done_code  = code_q;
    done_bytes = commit_q;
  end
endmodule

// File: rtl/bytepack_wr.sv
module bytepack_wr
  import bytepack_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LEN_W = 12,
  parameter int unsigned MEM_BYTES = 32'h0010_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              wr_valid,
  input  logic              wr_ready,
  input  logic              wr_fail,
  output logic [ADDR_W-3:0] wr_word_addr,
  output logic [31:0]       wr_data,
  output logic              done,
  output logic [1:0]        done_code,
  output logic [LEN_W-1:0]  done_bytes
);
  logic              len_zero, past_end;
  logic              buf_clr, buf_wr;
  logic [LANE_W-1:0] lane;

  bytepack_range #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_BYTES(MEM_BYTES)
  ) u_range (
    .addr(cmd_addr), .len(cmd_len),
    .len_zero(len_zero), .past_end(past_end)
  );

  bytepack_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .len_zero(len_zero), .past_end(past_end),
    .in_valid(in_valid), .wr_ready(wr_ready), .wr_fail(wr_fail),
    .cmd_ready(cmd_ready), .in_ready(in_ready), .wr_valid(wr_valid),
    .word_addr(wr_word_addr), .buf_clr(buf_clr), .buf_wr(buf_wr),
    .lane(lane), .done(done), .done_code(done_code), .done_bytes(done_bytes)
  );

  bytepack_lanes u_lanes (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_lane(lane), .wr_byte(in_byte), .word(wr_data)
  );
endmodule

// File: rtl/bytepack_wr_chk.sv
module bytepack_wr_chk #(
  parameter int ADDR_W = 20,
  parameter int LEN_W = 12,
  parameter int unsigned MEM_BYTES = 32'h0010_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              wr_fail,
  input logic [ADDR_W-3:0] wr_word_addr,
  input logic [31:0]       wr_data,
  input logic              done,
  input logic [1:0]        done_code,
  input logic [LEN_W-1:0]  done_bytes
);
  localparam int SW = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;
  logic over;
  assign over = ({1'b0, SW'(cmd_addr)} + {1'b0, SW'(cmd_len)}) > (SW+1)'(MEM_BYTES);

  p_zero_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_len == '0) |=> (done && done_code == 2'd0 && done_bytes == '0));

  p_range_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_len != '0 && over) |=> (done && done_code == 2'd1 && !wr_valid));

  p_fail_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_fail) |=> (done && done_code == 2'd2 && !wr_valid && $stable(done_bytes)));

  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_word_addr) && $stable(wr_data)));

  p_no_take_while_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && wr_valid));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!in_ready && !wr_valid));
endmodule

bind bytepack_wr bytepack_wr_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_BYTES(MEM_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_addr(cmd_addr), .cmd_len(cmd_len), .in_ready(in_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_fail(wr_fail),
  .wr_word_addr(wr_word_addr), .wr_data(wr_data), .done(done),
  .done_code(done_code), .done_bytes(done_bytes)
);

// File: tb/bytepack_wr_tb.sv
module bytepack_wr_tb;
  localparam int ADDR_W = 20;
  localparam int LEN_W = 12;
  localparam int unsigned MEM_BYTES = 32'h0010_0000;
  localparam logic [1:0] C_OK = 2'd0, C_RANGE = 2'd1, C_WFAIL = 2'd2;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0] cmd_len;
  logic in_valid, in_ready;
  logic [7:0] in_byte;
  logic wr_valid, wr_ready, wr_fail;
  logic [ADDR_W-3:0] wr_word_addr;
  logic [31:0] wr_data;
  logic done;
  logic [1:0] done_code;
  logic [LEN_W-1:0] done_bytes;

  int checks = 0, errors = 0, cyc = 0;
  int fail_word = -1, words_seen = 0, stall_cnt = 0;
  bit stall_mode = 0, stop_feed = 0;
  logic [ADDR_W-3:0] q_addr[$];
  logic [31:0] q_data[$];
  bit held = 0;
  logic [ADDR_W-3:0] held_addr;
  logic [31:0] held_data;

  always #2 clk = ~clk;

  bytepack_wr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MEM_BYTES(MEM_BYTES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_fail(wr_fail),
    .wr_word_addr(wr_word_addr), .wr_data(wr_data), .done(done),
    .done_code(done_code), .done_bytes(done_bytes)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 29 + i * 13 + 5) & 255);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // writer model: ready pattern and failure injection, driven after the edge
  always @(posedge clk) begin
    #1;
    stall_cnt = stall_cnt + 1;
    wr_ready = stall_mode ? ((stall_cnt % 3) == 2) : 1'b1;
    wr_fail = (fail_word >= 0) && (words_seen == fail_word);
  end

  // monitor: scoreboard compare at each accepted word, plus hold check (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        chk(wr_valid && wr_word_addr == held_addr && wr_data == held_data, "R8",
            "stalled word changed", {12'h0, wr_word_addr, wr_data}, {12'h0, held_addr, held_data});
      end
      held = wr_valid && !wr_ready;
      held_addr = wr_word_addr;
      held_data = wr_data;
      if (wr_valid && wr_ready) begin
        if (q_addr.size() == 0) begin
          chk(1'b0, "R3", "unexpected word", {12'h0, wr_word_addr, wr_data}, 64'h0);
        end else begin
          logic [ADDR_W-3:0] ea;
          logic [31:0] ed;
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          chk(wr_word_addr == ea && wr_data == ed, "R1 R2 R3 R4", "word",
              {12'h0, wr_word_addr, wr_data}, {12'h0, ea, ed});
        end
        words_seen = words_seen + 1;
      end
    end
  end

  task automatic feed(input int len, input int seed, input bit gap);
    for (int i = 0; i < len && !stop_feed; i++) begin
      bit got;
      in_valid = 1'b1;
      in_byte = pat(seed, i);
      got = 1'b0;
      while (!got && !stop_feed) begin
        @(negedge clk);
        got = in_ready;
        @(posedge clk);
        #1;
      end
      in_valid = 1'b0;
      if (gap && (i % 3) == 1) begin
        @(posedge clk);
        #1;
      end
    end
    in_valid = 1'b0;
  endtask

  task automatic run(input logic [ADDR_W-1:0] a, input int len, input int seed,
                     input int fk, input bit stall, input bit gap,
                     input logic [1:0] ecode, input string tag);
    int lane, pend, nw, ecount, waited;
    logic [31:0] w;
    logic [ADDR_W-3:0] wa;
    logic [1:0] got_code;
    logic [LEN_W-1:0] got_bytes;
    ecount = 0;
    nw = 0;
    if (ecode != C_RANGE && len > 0) begin
      wa = a[ADDR_W-1:2];
      lane = int'(a[1:0]);
      w = '1;
      pend = 0;
      for (int i = 0; i < len; i++) begin
        w[lane*8 +: 8] = pat(seed, i);
        lane++;
        pend++;
        if (lane == 4 || i == len - 1) begin
          if (fk < 0 || nw <= fk) begin
            q_addr.push_back(wa);
            q_data.push_back(w);
          end
          if (fk < 0 || nw < fk) ecount += pend;
          nw++;
          wa = wa + 1'b1;
          lane = 0;
          w = '1;
          pend = 0;
        end
      end
    end
    fail_word = fk;
    stall_mode = stall;
    words_seen = 0;
    stop_feed = 0;
    @(posedge clk);
    #1;
    cmd_valid = 1'b1;
    cmd_addr = a;
    cmd_len = LEN_W'(len);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
    waited = 0;
    got_code = 2'd3;
    got_bytes = '0;
    fork
      begin
        if (ecode != C_RANGE) feed(len, seed, gap);
      end
      begin
        while (!done) begin
          @(negedge clk);
          waited++;
        end
        got_code = done_code;
        got_bytes = done_bytes;
        stop_feed = 1;
      end
    join
    fail_word = -1;
    chk(got_code == ecode, tag, "done code", 64'(got_code), 64'(ecode));
    chk(got_bytes == LEN_W'(ecount), tag, "bytes committed", 64'(got_bytes), 64'(ecount));
    chk(q_addr.size() == 0, tag, "words missing", 64'(q_addr.size()), 64'h0);
    if (len == 0) chk(waited == 0, "R5", "zero length latency", 64'(waited), 64'h0);
    q_addr.delete();
    q_data.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_addr = '0;
    cmd_len = '0;
    in_valid = 1'b0;
    in_byte = '0;
    wr_ready = 1'b0;
    wr_fail = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !in_ready && !wr_valid && !done, "R10", "reset state",
        {60'h0, cmd_ready, in_ready, wr_valid, done}, 64'h8);

    run(20'd0, 16, 1, -1, 0, 0, C_OK, "R3 R9 aligned");
    run(20'd5, 2, 2, -1, 0, 0, C_OK, "R1 R2 inner");
    run(20'd3, 10, 3, -1, 1, 1, C_OK, "R1 R3 R4 R8 stall");
    run(20'd8, 7, 4, -1, 1, 0, C_OK, "R4 tail3");
    run(20'd2, 1, 5, -1, 0, 1, C_OK, "R2 single");
    run(20'd100, 0, 6, -1, 0, 0, C_OK, "R5 empty");
    run(20'(MEM_BYTES - 2), 3, 7, -1, 0, 0, C_RANGE, "R6 over");
    run(20'(MEM_BYTES - 4), 4, 8, -1, 1, 0, C_OK, "R6 boundary");
    run(20'd2, 12, 9, 1, 1, 0, C_WFAIL, "R7 fail second");
    run(20'd0, 8, 10, 0, 0, 0, C_WFAIL, "R7 fail first");
    run(20'd1, 9, 11, -1, 1, 1, C_OK, "R7 R9 recovery");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule